// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block is a small memory-mapped register bank on a single-cycle APB-style slave port. It holds three 32-bit control words: an address-remap word, an error-interrupt mask word and a per-master idle-request word. Each word has three addresses. One address reads and writes the whole word. A second address sets the bits where the written data has a 1. A third address clears those bits. Software can therefore change one bit without a read-modify-write sequence, and a concurrent update of another bit cannot be lost.

Two further words are read-only and sample hardware inputs directly: the idle acknowledge and the idle status of each interconnect master. All three control words drive output ports from their registers. An access the bank cannot honour returns the slave-error response. This covers writes to a read-only word and any access to an unmapped or misaligned offset.

Top module: `setclr_reg_bank`

## Requirements
- R1: While reset is held, and after it is released, the remap, mask and idle-request outputs are 0.
- R2: A write access to a value address (remap 0x80, mask 0x90, idle request 0xCC) loads the full 32-bit write data into that word on the clock edge that ends the access phase, with no slave error.
- R3: A write access to a set alias (remap 0x84, mask 0x94, idle request 0xC4) makes the word equal to its old value OR the write data. Data bits of 0 leave their bits unchanged.
- R4: A write access to a clear alias (remap 0x88, mask 0x98, idle request 0xC8) makes the word equal to its old value AND NOT the write data. Data bits of 0 leave their bits unchanged.
- R5: A read access to a value address returns the current word with no slave error.
- R6: A read access to any set or clear alias completes with no slave error and returns 0.
- R7: A read access to 0xD0 returns the idle-acknowledge input, and a read access to 0xD4 returns the idle-status input. Both are sampled combinationally in the access cycle, with no slave error.
- R8: A write access to 0xD0 or 0xD4 raises the slave error and changes no control word.
- R9: An access to an offset that is unmapped or not word-aligned, or that lies above 0xFF within the address window, raises the slave error. A read of such an offset returns 0, and a write to it changes no control word.
- R10: The state changes only in an access phase with select, enable and write all high. A setup phase alone, or enable without select, changes nothing.
- R11: A write to one group's address changes only that group's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | ADDR_W (9) | Byte offset within the block's window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Slave error, valid in the access phase |
| idle_ack_i | input | 32 | Per-master idle acknowledge |
| idle_stat_i | input | 32 | Per-master idle status |
| remap_o | output | 32 | Address-remap control word |
| irq_mask_o | output | 32 | Error-interrupt mask word |
| idle_req_o | output | 32 | Per-master idle-request word |

## Verification
A read of an idle status word and a change on the matching hardware input can happen in the same cycle. The bench changes the idle-acknowledge input at the start of a read's access phase and expects the new value, not the old one, on the read data in that cycle. A set- or clear-alias write and a change on the status inputs can also share a clock edge. The bench sweeps every offset of the window, once as a read and once as a write, while the status inputs move. After each access it compares all three control outputs against its arithmetic model, so a write that leaks into another group, or an input change that corrupts a word, shows up at the ports.

// File: rtl/setclr_pkg.sv
package setclr_pkg;

  localparam int NGRP = 3;   // remap, mask, idle request
  localparam int NRO  = 2;   // idle ack, idle status
  localparam int OFF_W = 8;  // decoded offset bits

  localparam logic [OFF_W-1:0] GRP_VAL_OFF [NGRP] = '{8'h80, 8'h90, 8'hCC};
  localparam logic [OFF_W-1:0] GRP_SET_OFF [NGRP] = '{8'h84, 8'h94, 8'hC4};
  localparam logic [OFF_W-1:0] GRP_CLR_OFF [NGRP] = '{8'h88, 8'h98, 8'hC8};
  localparam logic [OFF_W-1:0] RO_OFF      [NRO]  = '{8'hD0, 8'hD4};

  localparam int GRP_REMAP = 0;
  localparam int GRP_MASK  = 1;
  localparam int GRP_IDLE  = 2;

endpackage

// File: rtl/setclr_rst_sync.sv
module setclr_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/setclr_decode.sv
module setclr_decode
  import setclr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NGRP-1:0]   val_hit,
  output logic [NGRP-1:0]   set_hit,
  output logic [NGRP-1:0]   clr_hit,
  output logic [NRO-1:0]    ro_hit,
  output logic              mapped
);

  logic             hi_ok;
  logic [OFF_W-1:0] off;

  assign off = addr[OFF_W-1:0];

  generate
    if (ADDR_W > OFF_W) begin : g_hi
      assign hi_ok = ~|addr[ADDR_W-1:OFF_W];
    end else begin : g_nohi
      assign hi_ok = 1'b1;
    end
  endgenerate

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign val_hit[g] = hi_ok && (off == GRP_VAL_OFF[g]);
      assign set_hit[g] = hi_ok && (off == GRP_SET_OFF[g]);
      assign clr_hit[g] = hi_ok && (off == GRP_CLR_OFF[g]);
    end
    for (genvar r = 0; r < NRO; r++) begin : g_ro
      assign ro_hit[r] = hi_ok && (off == RO_OFF[r]);
    end
  endgenerate

  assign mapped = |{val_hit, set_hit, clr_hit, ro_hit};

endmodule

// File: rtl/setclr_alias_word.sv
module setclr_alias_word #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_val,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic         upd_en;
  logic [W-1:0] q_nxt;

  always_comb begin
    upd_en = wr_val | wr_set | wr_clr;
    q_nxt  = q;
    if (wr_val) begin
      q_nxt = wdata;
    end else if (wr_set) begin
      q_nxt = q | wdata;
    end else if (wr_clr) begin
      q_nxt = q & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (upd_en) begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/setclr_reg_bank.sv
module setclr_reg_bank
  import setclr_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pslverr,
  input  logic [DATA_W-1:0] idle_ack_i,
  input  logic [DATA_W-1:0] idle_stat_i,
  output logic [DATA_W-1:0] remap_o,
  output logic [DATA_W-1:0] irq_mask_o,
  output logic [DATA_W-1:0] idle_req_o
);

  logic              rst_sync_n;
  logic              access;
  logic              wr_acc;
  logic              rd_acc;
  logic [NGRP-1:0]   val_hit;
  logic [NGRP-1:0]   set_hit;
  logic [NGRP-1:0]   clr_hit;
  logic [NRO-1:0]    ro_hit;
  logic              mapped;
  logic [DATA_W-1:0] word_q  [NGRP];
  logic [DATA_W-1:0] ro_word [NRO];

  setclr_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  setclr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr    (paddr),
    .val_hit (val_hit),
    .set_hit (set_hit),
    .clr_hit (clr_hit),
    .ro_hit  (ro_hit),
    .mapped  (mapped)
  );

  assign access = psel & penable;
  assign wr_acc = access & pwrite;
  assign rd_acc = access & ~pwrite;

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_word
      setclr_alias_word #(.W(DATA_W)) u_word (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .wr_val (wr_acc & val_hit[g]),
        .wr_set (wr_acc & set_hit[g]),
        .wr_clr (wr_acc & clr_hit[g]),
        .wdata  (pwdata),
        .q      (word_q[g])
      );
    end
  endgenerate

  assign ro_word[0] = idle_ack_i;
  assign ro_word[1] = idle_stat_i;

  always_comb begin
    prdata = '0;
    if (rd_acc) begin
      for (int g = 0; g < NGRP; g++) begin
        if (val_hit[g]) prdata = prdata | word_q[g];
      end
      for (int r = 0; r < NRO; r++) begin
        if (ro_hit[r]) prdata = prdata | ro_word[r];
      end
    end
  end

  assign pslverr = access & (~mapped | (pwrite & (|ro_hit)));

  assign remap_o    = word_q[GRP_REMAP];
  assign irq_mask_o = word_q[GRP_MASK];
  assign idle_req_o = word_q[GRP_IDLE];

endmodule

// File: rtl/setclr_reg_bank_chk.sv
module setclr_reg_bank_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              pslverr,
  input logic [DATA_W-1:0] idle_ack_i,
  input logic [DATA_W-1:0] remap_o,
  input logic [DATA_W-1:0] irq_mask_o,
  input logic [DATA_W-1:0] idle_req_o
);

  localparam logic [ADDR_W-1:0] A_REMAP_VAL = ADDR_W'(9'h080);
  localparam logic [ADDR_W-1:0] A_REMAP_SET = ADDR_W'(9'h084);
  localparam logic [ADDR_W-1:0] A_REMAP_CLR = ADDR_W'(9'h088);
  localparam logic [ADDR_W-1:0] A_MASK_SET  = ADDR_W'(9'h094);
  localparam logic [ADDR_W-1:0] A_IDLE_CLR  = ADDR_W'(9'h0C8);
  localparam logic [ADDR_W-1:0] A_ACK       = ADDR_W'(9'h0D0);
  localparam logic [ADDR_W-1:0] A_STAT      = ADDR_W'(9'h0D4);

  logic wr_a, rd_a;
  assign wr_a = psel && penable && pwrite;
  assign rd_a = psel && penable && !pwrite;

  assert_load_remap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a && paddr == A_REMAP_VAL |=> remap_o == $past(pwdata));

  assert_set_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a && paddr == A_MASK_SET |=> irq_mask_o == ($past(irq_mask_o) | $past(pwdata)));

  assert_clr_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a && paddr == A_IDLE_CLR |=> idle_req_o == ($past(idle_req_o) & ~$past(pwdata)));

  assert_alias_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a && (paddr == A_REMAP_SET || paddr == A_REMAP_CLR) |-> prdata == '0 && !pslverr);

  assert_ack_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a && paddr == A_ACK |-> prdata == idle_ack_i && !pslverr);

  assert_ro_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a && (paddr == A_ACK || paddr == A_STAT) |-> pslverr);

  assert_ro_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_a && (paddr == A_ACK || paddr == A_STAT)
    |=> $stable(remap_o) && $stable(irq_mask_o) && $stable(idle_req_o));

  assert_no_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_a |=> $stable(remap_o) && $stable(irq_mask_o) && $stable(idle_req_o));

endmodule

bind setclr_reg_bank setclr_reg_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .psel       (psel),
  .penable    (penable),
  .pwrite     (pwrite),
  .paddr      (paddr),
  .pwdata     (pwdata),
  .prdata     (prdata),
  .pslverr    (pslverr),
  .idle_ack_i (idle_ack_i),
  .remap_o    (remap_o),
  .irq_mask_o (irq_mask_o),
  .idle_req_o (idle_req_o)
);

// File: tb/setclr_reg_bank_tb.sv
module setclr_reg_bank_tb;

  localparam int AW = 9;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [DW-1:0] pwdata;
  logic [DW-1:0] prdata;
  logic          pslverr;
  logic [DW-1:0] idle_ack_i, idle_stat_i;
  logic [DW-1:0] remap_o, irq_mask_o, idle_req_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] m [3];

  setclr_reg_bank #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
    .idle_ack_i(idle_ack_i), .idle_stat_i(idle_stat_i),
    .remap_o(remap_o), .irq_mask_o(irq_mask_o), .idle_req_o(idle_req_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_outs(input string req);
    chk(req, remap_o, m[0]);
    chk(req, irq_mask_o, m[1]);
    chk(req, idle_req_o, m[2]);
  endtask

  // Expected response and model update, from the requirements.
  task automatic model(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                       output logic [DW-1:0] er, output logic ee, output string req);
    er = '0; ee = 1'b0; req = "R9";
    if (a[1:0] != 2'b00 || a[8]) begin
      ee = 1'b1;
    end else begin
      case (a[7:0])
        8'h80: begin req = w ? "R2" : "R5"; if (w) m[0] = d; else er = m[0]; end
        8'h90: begin req = w ? "R2" : "R5"; if (w) m[1] = d; else er = m[1]; end
        8'hCC: begin req = w ? "R2" : "R5"; if (w) m[2] = d; else er = m[2]; end
        8'h84: begin req = w ? "R3" : "R6"; if (w) m[0] = m[0] | d; end
        8'h94: begin req = w ? "R3" : "R6"; if (w) m[1] = m[1] | d; end
        8'hC4: begin req = w ? "R3" : "R6"; if (w) m[2] = m[2] | d; end
        8'h88: begin req = w ? "R4" : "R6"; if (w) m[0] = m[0] & ~d; end
        8'h98: begin req = w ? "R4" : "R6"; if (w) m[1] = m[1] & ~d; end
        8'hC8: begin req = w ? "R4" : "R6"; if (w) m[2] = m[2] & ~d; end
        8'hD0: begin req = w ? "R8" : "R7"; if (w) ee = 1'b1; else er = idle_ack_i; end
        8'hD4: begin req = w ? "R8" : "R7"; if (w) ee = 1'b1; else er = idle_stat_i; end
        default: ee = 1'b1;
      endcase
    end
  endtask

  task automatic bus(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
    logic [DW-1:0] er;
    logic ee;
    string req;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    model(a, w, d, er, ee, req);
    chk(req, {31'b0, pslverr}, {31'b0, ee});
    if (!w) chk(req, prdata, er);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    #1;
    chk_outs("R11");
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] pat;
    rst_n = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; idle_ack_i = '0; idle_stat_i = '0;
    m[0] = '0; m[1] = '0; m[2] = '0;
    repeat (3) @(negedge clk);
    #1 chk_outs("R1");
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk_outs("R1");

    // R10: setup phase only, and enable without select
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = 9'h080; pwdata = 32'hFFFF_FFFF;
    @(negedge clk);
    psel = 1'b0; penable = 1'b1; paddr = 9'h094;
    @(negedge clk);
    penable = 1'b0; pwrite = 1'b0;
    #1 chk_outs("R10");

    // Full sweep: every offset read then written, status inputs moving
    for (int a = 0; a < 512; a++) begin
      @(negedge clk);
      idle_ack_i  = 32'h1357_9BDF ^ (a * 32'h0001_0203);
      idle_stat_i = ~idle_ack_i ^ 32'(a);
      bus(AW'(a), 1'b0, '0);
      pat = 32'hA5C3_0F96 ^ (32'(a) * 32'h0101_0101) ^ {23'(a), 9'h0};
      bus(AW'(a), 1'b1, pat);
    end

    // Walking bits through set and clear aliases of each group
    for (int g = 0; g < 3; g++) begin
      logic [AW-1:0] va, sa, ca;
      va = (g == 0) ? 9'h080 : (g == 1) ? 9'h090 : 9'h0CC;
      sa = (g == 0) ? 9'h084 : (g == 1) ? 9'h094 : 9'h0C4;
      ca = (g == 0) ? 9'h088 : (g == 1) ? 9'h098 : 9'h0C8;
      bus(va, 1'b1, 32'h0);
      for (int b = 0; b < 32; b++) bus(sa, 1'b1, 32'h1 << b);   // R3
      bus(va, 1'b0, '0);
      bus(sa, 1'b1, 32'h0);                                     // R3 zero data
      for (int b = 0; b < 32; b += 2) bus(ca, 1'b1, 32'h1 << b); // R4
      bus(ca, 1'b1, 32'h0);                                     // R4 zero data
      bus(va, 1'b0, '0);
    end

    // Status input changing in the same access cycle as its read (R7)
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 9'h0D0;
    @(negedge clk);
    penable = 1'b1; idle_ack_i = 32'hC0DE_F00D;
    #1 chk("R7", prdata, 32'hC0DE_F00D);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;

    // Reset again returns all words to 0 (R1)
    @(negedge clk) rst_n = 1'b0;
    m[0] = '0; m[1] = '0; m[2] = '0;
    #1 chk_outs("R1");

    done = 1;
    finish_run();
  end

endmodule